// File: doc/BRIEF.md
# Renaming Issue Buffer with Result-Bus Wakeup

This block sits between instruction decode and a set of functional units. It holds a small circular window of instruction slots. Each decoded instruction takes the next free slot, and the slot's index becomes the tag that stands for the instruction's destination register. A rename table records, for every architectural register, either a present value or the tag of the slot that will produce it. Decode looks up both sources in that table, so each operand enters its slot either as a value or as a tag that it is still waiting for.

Functional units report finished work on a single result bus that carries a tag and a value. Every waiting operand and every rename-table entry that holds that tag picks up the value. The slot with that tag is marked finished. Each cycle the block sends at most one slot whose operands are both present to execution, choosing the oldest one. Slots are reclaimed strictly in allocation order, and only once the oldest slot has finished.

Top module: `rrb_core`

## Requirements
- R1: After a synchronous active-high reset, `dec_ready` is 1, `disp_valid` is 0 and `alloc_tag` is 0.
- R2: An instruction is accepted in each cycle in which `dec_valid` and `dec_ready` are both 1. It occupies slot `alloc_tag`, and `alloc_tag` then advances by one, modulo the slot count.
- R3: `dec_ready` is 0 while all slots are occupied. In that state an instruction offered on `dec_valid` is not taken, and `alloc_tag` does not move.
- R4: An accepted instruction's destination register is mapped to its slot tag. A later instruction that reads that register waits for that tag rather than using an older value.
- R5: When `res_valid` is 1, every waiting operand whose tag equals `res_tag` takes `res_data` and becomes present.
- R6: A rename-table entry that still holds `res_tag` when the result is broadcast is replaced by `res_data`, and that value is present from then on.
- R7: An instruction decoded in the same cycle as a broadcast of the tag it reads sees the broadcast value. A source that names the instruction's own destination reads the mapping that was in place before the instruction.
- R8: A slot is offered for dispatch only when it is in use, has not yet been dispatched and has both operands present. `disp_a` and `disp_b` carry the operand values.
- R9: Among eligible slots, the dispatched one is the first found when counting upward from the oldest occupied slot, modulo the slot count.
- R10: At most one slot is dispatched per cycle, and a dispatched slot is not dispatched again while it remains allocated.
- R11: A broadcast with tag T marks slot T as finished. Space is reclaimed only by advancing past the oldest slot, one per cycle, when that slot is finished. A finished younger slot frees nothing while an older one is still pending.
- R12: At reset, each architectural register i holds the present value i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| dec_valid | input | 1 | Decode offers an instruction |
| dec_op | input | OP_W (4) | Operation code of the offered instruction |
| dec_dst | input | REG_W (3) | Destination architectural register |
| dec_src_a | input | REG_W (3) | First source architectural register |
| dec_src_b | input | REG_W (3) | Second source architectural register |
| dec_ready | output | 1 | A slot is free to accept an instruction |
| alloc_tag | output | TAG_W (3) | Tag the next accepted instruction receives |
| res_valid | input | 1 | Result bus carries a result |
| res_tag | input | TAG_W (3) | Tag of the finished instruction |
| res_data | input | DATA_W (16) | Result value |
| disp_valid | output | 1 | A slot is dispatched this cycle |
| disp_tag | output | TAG_W (3) | Tag of the dispatched slot |
| disp_op | output | OP_W (4) | Operation code of the dispatched slot |
| disp_a | output | DATA_W (16) | First operand value |
| disp_b | output | DATA_W (16) | Second operand value |

## Verification
The hardest state to reach is a full window in which younger slots have already finished while the oldest slot is still pending. Only there does in-order reclamation differ from simply counting free slots. The bench withholds results for a stretch of cycles until decode fills every slot. It then returns results in an order that is random and delayed, so completions arrive out of order while `dec_valid` keeps pressing against a full buffer. Broadcasts land in the same cycle as decodes that read the broadcast tag often enough to exercise the forwarding path.

// File: rtl/rrb_pkg.sv
package rrb_pkg;
    parameter int SLOTS     = 8;
    parameter int ARCH_REGS = 8;
    parameter int DATA_W    = 16;
    parameter int OP_W      = 4;

    localparam int TAG_W = $clog2(SLOTS);
    localparam int REG_W = $clog2(ARCH_REGS);

    typedef logic [TAG_W-1:0]  tag_t;
    typedef logic [REG_W-1:0]  reg_t;
    typedef logic [DATA_W-1:0] data_t;
    typedef logic [OP_W-1:0]   op_t;

    // operand: value when pres is set, otherwise body holds a producer tag
    typedef struct packed {
        logic  pres;
        data_t body;
    } opnd_t;

    typedef struct packed {
        logic  valid;
        tag_t  tag;
        data_t data;
    } bus_t;

    typedef struct packed {
        logic  used;
        logic  sent;
        op_t   op;
        opnd_t a;
        opnd_t b;
    } slot_t;

    function automatic opnd_t snoop(opnd_t o, bus_t b);
        opnd_t r;
        r = o;
        if (!o.pres && b.valid && (o.body[TAG_W-1:0] == b.tag)) begin
            r.pres = 1'b1;
            r.body = b.data;
        end
        return r;
    endfunction

    function automatic opnd_t waiting_on(tag_t t);
        opnd_t r;
        r.pres = 1'b0;
        r.body = data_t'(t);
        return r;
    endfunction
endpackage

// File: rtl/rrb_rename.sv
module rrb_rename import rrb_pkg::*; (
    input  logic  clk,
    input  logic  rst,
    input  bus_t  bus,
    input  logic  wr_en,
    input  reg_t  wr_reg,
    input  tag_t  wr_tag,
    input  reg_t  rd_a,
    input  reg_t  rd_b,
    output opnd_t op_a,
    output opnd_t op_b
);
    opnd_t map_q [ARCH_REGS];

    // lookups see a result broadcast in the same cycle
    always_comb begin
        op_a = snoop(map_q[rd_a], bus);
        op_b = snoop(map_q[rd_b], bus);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < ARCH_REGS; i++) begin
                map_q[i].pres <= 1'b1;
                map_q[i].body <= data_t'(i);
            end
        end else begin
            for (int i = 0; i < ARCH_REGS; i++)
                map_q[i] <= snoop(map_q[i], bus);
            if (wr_en)
                map_q[wr_reg] <= waiting_on(wr_tag);
        end
    end
endmodule

// File: rtl/rrb_slot.sv
module rrb_slot import rrb_pkg::*; #(
    parameter int SLOT_ID = 0
) (
    input  logic  clk,
    input  logic  rst,
    input  bus_t  bus,
    input  logic  alloc,
    input  op_t   alloc_op,
    input  opnd_t alloc_a,
    input  opnd_t alloc_b,
    input  logic  grant,
    output logic  in_use,
    output logic  ready,
    output op_t   op_o,
    output data_t a_o,
    output data_t b_o
);
    slot_t st_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else if (alloc) begin
            st_q.used <= 1'b1;
            st_q.sent <= 1'b0;
            st_q.op   <= alloc_op;
            st_q.a    <= alloc_a;
            st_q.b    <= alloc_b;
        end else begin
            st_q.a <= snoop(st_q.a, bus);
            st_q.b <= snoop(st_q.b, bus);
            if (grant)
                st_q.sent <= 1'b1;
            if (st_q.used && bus.valid && (bus.tag == tag_t'(SLOT_ID)))
                st_q.used <= 1'b0;
        end
    end

    assign in_use = st_q.used;
    assign ready  = st_q.used && !st_q.sent && st_q.a.pres && st_q.b.pres;
    assign op_o   = st_q.op;
    assign a_o    = st_q.a.body;
    assign b_o    = st_q.b.body;
endmodule

// File: rtl/rrb_select.sv
module rrb_select import rrb_pkg::*; (
    input  logic [SLOTS-1:0] req,
    input  tag_t             oldest,
    output logic             found,
    output tag_t             pick
);
    always_comb begin
        found = 1'b0;
        pick  = '0;
        for (int i = 0; i < SLOTS; i++) begin
            tag_t idx;
            idx = oldest + tag_t'(i);
            if (!found && req[idx]) begin
                found = 1'b1;
                pick  = idx;
            end
        end
    end
endmodule

// File: rtl/rrb_core.sv
module rrb_core import rrb_pkg::*; (
    input  logic              clk,
    input  logic              rst,
    input  logic              dec_valid,
    input  logic [OP_W-1:0]   dec_op,
    input  logic [REG_W-1:0]  dec_dst,
    input  logic [REG_W-1:0]  dec_src_a,
    input  logic [REG_W-1:0]  dec_src_b,
    output logic              dec_ready,
    output logic [TAG_W-1:0]  alloc_tag,
    input  logic              res_valid,
    input  logic [TAG_W-1:0]  res_tag,
    input  logic [DATA_W-1:0] res_data,
    output logic              disp_valid,
    output logic [TAG_W-1:0]  disp_tag,
    output logic [OP_W-1:0]   disp_op,
    output logic [DATA_W-1:0] disp_a,
    output logic [DATA_W-1:0] disp_b
);
    logic [TAG_W:0]   head_q, tail_q;
    logic [SLOTS-1:0] use_vec, ready_vec;
    op_t              op_arr [SLOTS];
    data_t            a_arr  [SLOTS];
    data_t            b_arr  [SLOTS];
    bus_t             bus;
    opnd_t            look_a, look_b;
    logic             full, empty, do_alloc, do_free;

    assign bus.valid = res_valid;
    assign bus.tag   = res_tag;
    assign bus.data  = res_data;

    assign full      = (head_q[TAG_W] != tail_q[TAG_W]) &&
                       (head_q[TAG_W-1:0] == tail_q[TAG_W-1:0]);
    assign empty     = (head_q == tail_q);
    assign dec_ready = !full;
    assign alloc_tag = tail_q[TAG_W-1:0];
    assign do_alloc  = dec_valid && !full;
    assign do_free   = !empty && !use_vec[head_q[TAG_W-1:0]];

    always_ff @(posedge clk) begin
        if (rst) begin
            head_q <= '0;
            tail_q <= '0;
        end else begin
            if (do_alloc) tail_q <= tail_q + 1'b1;
            if (do_free)  head_q <= head_q + 1'b1;
        end
    end

    rrb_rename u_rename (
        .clk    (clk),
        .rst    (rst),
        .bus    (bus),
        .wr_en  (do_alloc),
        .wr_reg (dec_dst),
        .wr_tag (tail_q[TAG_W-1:0]),
        .rd_a   (dec_src_a),
        .rd_b   (dec_src_b),
        .op_a   (look_a),
        .op_b   (look_b)
    );

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        logic this_alloc, this_grant;
        assign this_alloc = do_alloc && (tail_q[TAG_W-1:0] == tag_t'(g));
        assign this_grant = disp_valid && (disp_tag == tag_t'(g));
        rrb_slot #(.SLOT_ID(g)) u_slot (
            .clk      (clk),
            .rst      (rst),
            .bus      (bus),
            .alloc    (this_alloc),
            .alloc_op (dec_op),
            .alloc_a  (look_a),
            .alloc_b  (look_b),
            .grant    (this_grant),
            .in_use   (use_vec[g]),
            .ready    (ready_vec[g]),
            .op_o     (op_arr[g]),
            .a_o      (a_arr[g]),
            .b_o      (b_arr[g])
        );
    end

    rrb_select u_select (
        .req    (ready_vec),
        .oldest (head_q[TAG_W-1:0]),
        .found  (disp_valid),
        .pick   (disp_tag)
    );

    assign disp_op = op_arr[disp_tag];
    assign disp_a  = a_arr[disp_tag];
    assign disp_b  = b_arr[disp_tag];
endmodule

// File: rtl/rrb_core_chk.sv
module rrb_core_chk import rrb_pkg::*; (
    input logic             clk,
    input logic             rst,
    input logic             dec_valid,
    input logic             dec_ready,
    input logic [TAG_W-1:0] alloc_tag,
    input logic             disp_valid,
    input logic [TAG_W-1:0] disp_tag,
    input logic [SLOTS-1:0] ready_vec
);
    // R1
    reset_idle_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (dec_ready && !disp_valid && alloc_tag == '0));

    // R2
    alloc_step_chk: assert property (@(posedge clk) disable iff (rst)
        (dec_valid && dec_ready) |=> (alloc_tag == $past(alloc_tag) + 1'b1));

    // R3
    full_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !dec_ready |=> $stable(alloc_tag));

    // R8
    disp_ready_chk: assert property (@(posedge clk) disable iff (rst)
        disp_valid |-> ready_vec[disp_tag]);

    // R10
    no_redisp_chk: assert property (@(posedge clk) disable iff (rst)
        disp_valid |=> !(disp_valid && disp_tag == $past(disp_tag)));
endmodule

bind rrb_core rrb_core_chk chk_i (
    .clk        (clk),
    .rst        (rst),
    .dec_valid  (dec_valid),
    .dec_ready  (dec_ready),
    .alloc_tag  (alloc_tag),
    .disp_valid (disp_valid),
    .disp_tag   (disp_tag),
    .ready_vec  (ready_vec)
);

// File: tb/rrb_core_tb_top.sv
module rrb_core_tb_top;
    import rrb_pkg::*;

    logic clk = 0;
    logic rst = 1;
    always #4 clk = ~clk;

    logic              dec_valid = 0;
    logic [OP_W-1:0]   dec_op = 0;
    logic [REG_W-1:0]  dec_dst = 0, dec_src_a = 0, dec_src_b = 0;
    logic              dec_ready;
    logic [TAG_W-1:0]  alloc_tag;
    logic              res_valid = 0;
    logic [TAG_W-1:0]  res_tag = 0;
    logic [DATA_W-1:0] res_data = 0;
    logic              disp_valid;
    logic [TAG_W-1:0]  disp_tag;
    logic [OP_W-1:0]   disp_op;
    logic [DATA_W-1:0] disp_a, disp_b;

    rrb_core dut_i (.*);

    int total = 0, bad = 0;
    bit done = 0;

    // behavioural model state
    bit m_use [SLOTS], m_sent [SLOTS], m_pa [SLOTS], m_pb [SLOTS];
    int m_va [SLOTS], m_vb [SLOTS], m_op [SLOTS];
    bit rt_p [ARCH_REGS];
    int rt_v [ARCH_REGS];
    int m_head, m_tail, m_cnt;
    int pq_tag[$], pq_due[$];

    task automatic chk(bit ok, string req, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < SLOTS; i++) begin
            m_use[i] = 0; m_sent[i] = 0; m_pa[i] = 0; m_pb[i] = 0;
            m_va[i] = 0; m_vb[i] = 0; m_op[i] = 0;
        end
        for (int r = 0; r < ARCH_REGS; r++) begin
            rt_p[r] = 1; rt_v[r] = r;   // R12 reset contents
        end
        m_head = 0; m_tail = 0; m_cnt = 0;
    endtask

    initial begin
        #2000000;
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        #1;
        // R1 reset state
        chk(dec_ready == 1, "R1 dec_ready", dec_ready, 1);
        chk(disp_valid == 0, "R1 disp_valid", disp_valid, 0);
        chk(alloc_tag == 0, "R1 alloc_tag", alloc_tag, 0);

        for (int cyc = 0; cyc < 4000; cyc++) begin
            bit hold, m_found, free, alloc, lp_a, lp_b;
            int m_pick, lv_a, lv_b, s;
            @(negedge clk);
            hold = (cyc >= 300 && cyc < 360) || (cyc >= 1500 && cyc < 1540);
            // result bus: first pending entry whose time is up
            res_valid = 0;
            if (!hold) begin
                for (int k = 0; k < pq_tag.size(); k++) begin
                    if (!res_valid && pq_due[k] <= cyc) begin
                        res_valid = 1;
                        res_tag   = TAG_W'(pq_tag[k]);
                        res_data  = DATA_W'(pq_tag[k] * 29 + cyc * 7 + 100);
                        pq_tag.delete(k);
                        pq_due.delete(k);
                    end
                end
            end
            dec_valid = ($urandom % 4) != 0;
            dec_op    = OP_W'($urandom);
            dec_dst   = REG_W'($urandom);
            dec_src_a = REG_W'($urandom);
            dec_src_b = ($urandom % 3 == 0) ? dec_dst : REG_W'($urandom);
            #1;
            // model outputs
            m_found = 0; m_pick = 0;
            for (int i = 0; i < SLOTS; i++) begin
                s = (m_head + i) % SLOTS;
                if (!m_found && m_use[s] && !m_sent[s] && m_pa[s] && m_pb[s]) begin
                    m_found = 1; m_pick = s;
                end
            end
            chk(dec_ready == (m_cnt < SLOTS), "R3/R11 dec_ready", dec_ready, m_cnt < SLOTS);
            chk(alloc_tag == TAG_W'(m_tail), "R2 alloc_tag", alloc_tag, m_tail);
            chk(disp_valid == m_found, "R4/R8 disp_valid", disp_valid, m_found);
            if (m_found && disp_valid) begin
                chk(disp_tag == TAG_W'(m_pick), "R9/R10 disp_tag", disp_tag, m_pick);
                chk(disp_op == OP_W'(m_op[m_pick]), "R8 disp_op", disp_op, m_op[m_pick]);
                chk(disp_a == DATA_W'(m_va[m_pick]), "R5/R6/R7/R12 disp_a", disp_a, m_va[m_pick]);
                chk(disp_b == DATA_W'(m_vb[m_pick]), "R5/R6/R7/R12 disp_b", disp_b, m_vb[m_pick]);
            end
            @(posedge clk);
            // model update for this edge
            free  = (m_cnt > 0) && !m_use[m_head];
            alloc = dec_valid && (m_cnt < SLOTS);
            if (m_found) begin
                m_sent[m_pick] = 1;
                pq_tag.push_back(m_pick);
                pq_due.push_back(cyc + 1 + ($urandom % 6));
            end
            lp_a = rt_p[dec_src_a]; lv_a = rt_v[dec_src_a];
            lp_b = rt_p[dec_src_b]; lv_b = rt_v[dec_src_b];
            if (res_valid) begin
                if (!lp_a && lv_a == res_tag) begin lp_a = 1; lv_a = res_data; end
                if (!lp_b && lv_b == res_tag) begin lp_b = 1; lv_b = res_data; end
                for (int i = 0; i < SLOTS; i++) begin
                    if (m_use[i] && !m_pa[i] && m_va[i] == res_tag) begin m_pa[i] = 1; m_va[i] = res_data; end
                    if (m_use[i] && !m_pb[i] && m_vb[i] == res_tag) begin m_pb[i] = 1; m_vb[i] = res_data; end
                end
                m_use[res_tag] = 0;
                for (int r = 0; r < ARCH_REGS; r++)
                    if (!rt_p[r] && rt_v[r] == res_tag) begin rt_p[r] = 1; rt_v[r] = res_data; end
            end
            if (alloc) begin
                m_use[m_tail] = 1; m_sent[m_tail] = 0; m_op[m_tail] = dec_op;
                m_pa[m_tail] = lp_a; m_va[m_tail] = lv_a;
                m_pb[m_tail] = lp_b; m_vb[m_tail] = lv_b;
                rt_p[dec_dst] = 0; rt_v[dec_dst] = m_tail;
                m_tail = (m_tail + 1) % SLOTS;
            end
            if (free) m_head = (m_head + 1) % SLOTS;
            m_cnt = m_cnt + (alloc ? 1 : 0) - (free ? 1 : 0);
        end
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule